// File: doc/BRIEF.md
# Dual Frame FIFO With Occupancy Status

This block holds the data that moves between the register side of a serial bus controller and its bus engine. It carries two independent queues of 9-bit frames. The transmit queue is filled by register writes: each byte is placed in the upper eight bits of a frame, and the low bit, the acknowledge slot, is forced to 1. The bus engine then takes frames from it. The receive queue is filled by the bus engine with whole frames. The register side takes them as bytes, with the acknowledge slot dropped by a right shift of one.

Each queue holds eight entries when its enable bit is set. When the enable bit is clear, the queue acts as a one-entry holding buffer. Each queue reports a 3-bit occupancy field, a half-level flag, a full flag, and sticky overflow and underflow flags. The occupancy field only spans 0 to 7, so it shows 0 both when the queue is empty and when it holds eight entries. The full flag tells the two cases apart; on the receive side this flag is the receive-ready indication.

Each queue can be flushed on its own. A soft reset returns the whole block to its reset state, but only when the receive queue is already drained. A soft reset requested while receive data is still waiting is refused and raises a sticky busy error.

Top module: `dual_frame_fifo`

## Requirements
- R1: After the synchronous reset `rst`, both queues are empty. All occupancy fields, the half, full, overflow, underflow and busy-error flags, `tx_frame` and `rx_byte` read 0.
- R2: A byte pushed on `tx_byte` leaves on `tx_frame` as {byte, 1'b1}: the data sits in bits 8:1 and bit 0 is 1. Frames leave in push order. `tx_frame` always shows the oldest stored frame.
- R3: A frame pushed on `rx_frame` appears on `rx_byte` as frame bits 8:1, in push order. `rx_byte` always shows the oldest stored entry.
- R4: The occupancy field equals the number of stored entries modulo 8. With 8 entries it reads 0 and the full flag (`tx_full`, `rx_full`) is 1. The full flag is 1 whenever the count has reached the capacity (8 when enabled, 1 when bypassed).
- R5: The half flag is 1 exactly when the queue holds 4 or more entries.
- R6: A push while the queue is full is dropped, even if a pop happens in the same cycle. The stored contents are unchanged, and the sticky overflow flag is set until reset or an accepted soft reset.
- R7: A pop while the queue is empty changes nothing. The data output keeps showing the last frame popped (0 if none), and the sticky underflow flag is set.
- R8: With its enable bit clear, a queue holds at most one entry. It reports full at one entry, and a second push is dropped as in R6.
- R9: A flush strobe empties its own queue in one cycle and takes priority over a push or pop to that queue in the same cycle. It leaves the other queue, the sticky flags and the last popped value unchanged.
- R10: A soft reset while the receive queue is empty returns both queues and all flags, busy error included, to the reset state of R1. Any push or pop in that cycle is ignored.
- R11: A soft reset while the receive queue holds at least one entry is refused. No contents are lost, the other operations of that cycle proceed, and `busy_err` is set and stays set.
- R12: A push and a pop to the same queue in one cycle, with the queue neither empty nor full, leave the occupancy unchanged and keep the order of the entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit queue enable; 0 selects the one-entry buffer |
| rx_en | input | 1 | Receive queue enable; 0 selects the one-entry buffer |
| soft_rst | input | 1 | Soft reset request strobe |
| tx_push | input | 1 | Register side writes a byte to the transmit queue |
| tx_byte | input | 8 | Byte to transmit |
| tx_flush | input | 1 | Empty the transmit queue |
| tx_pop | input | 1 | Bus engine takes the head transmit frame |
| tx_frame | output | 9 | Head transmit frame, or the last one taken when empty |
| tx_level | output | 3 | Transmit occupancy modulo 8 |
| tx_half | output | 1 | Transmit queue holds 4 or more |
| tx_full | output | 1 | Transmit queue at capacity |
| tx_ovf | output | 1 | Sticky transmit overflow |
| tx_udf | output | 1 | Sticky transmit underflow |
| rx_push | input | 1 | Bus engine stores a received frame |
| rx_frame | input | 9 | Received frame, data in bits 8:1 |
| rx_flush | input | 1 | Empty the receive queue |
| rx_pop | input | 1 | Register side takes the head received byte |
| rx_byte | output | 8 | Head received byte, or the last one taken when empty |
| rx_level | output | 3 | Receive occupancy modulo 8 |
| rx_half | output | 1 | Receive queue holds 4 or more |
| rx_full | output | 1 | Receive queue at capacity (receive ready) |
| rx_ovf | output | 1 | Sticky receive overflow |
| rx_udf | output | 1 | Sticky receive underflow |
| busy_err | output | 1 | Sticky error: soft reset refused with receive data present |

## Verification
Every result of this block is due at the first rising edge after the strobe that causes it. Occupancy, the half and full flags, the sticky flags, the busy error and the show-ahead data outputs are all decoded from state registers that update on that one edge. The bench drives each operation at a falling edge and steps its queue model for that operation. It then compares every output against the model at the next falling edge, half a period after the edge that took the operation, so no comparison races the update. Directed sequences cover the wrap of the occupancy field at eight entries, drops, empty pops, bypass, flush, and both outcomes of the soft reset. A long seeded random run covers interleavings of all strobes, including enable changes while entries are stored.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;

    localparam int DATA_W     = 8;
    localparam int FRAME_W    = DATA_W + 1;
    localparam int FIFO_DEPTH = 8;

    typedef logic [FRAME_W-1:0] frame_t;

    // one cycle of requests to a single queue
    typedef struct packed {
        logic push;
        logic pop;
        logic flush;
    } fifo_req_t;

    // status flags of a single queue
    typedef struct packed {
        logic half;
        logic full;
        logic ovf;
        logic udf;
    } fifo_flags_t;

    // register-side byte to bus frame: data up one place, ack slot set
    function automatic frame_t frame_from_byte(input logic [DATA_W-1:0] b);
        return {b, 1'b1};
    endfunction

    // bus frame to register-side byte: drop the ack slot
    function automatic logic [DATA_W-1:0] byte_from_frame(input frame_t f);
        return f[FRAME_W-1:1];
    endfunction

endpackage

// File: rtl/fifo_level_enc.sv
module fifo_level_enc #(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1),
    parameter int LVL_W = $clog2(DEPTH)
) (
    input  logic [CNT_W-1:0] count,
    input  logic             en,
    output logic [LVL_W-1:0] level,
    output logic             half,
    output logic             full
);

    localparam logic [CNT_W-1:0] CAP_ON  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CAP_OFF = CNT_W'(1);
    localparam logic [CNT_W-1:0] HALF_AT = CNT_W'(DEPTH / 2);

    logic [CNT_W-1:0] cap;

    always_comb begin
        cap   = en ? CAP_ON : CAP_OFF;
        full  = (count >= cap);
        half  = (count >= HALF_AT);
        level = count[LVL_W-1:0];
    end

endmodule

// File: rtl/frame_fifo.sv
module frame_fifo
    import fifo_pair_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    parameter int W     = FRAME_W,
    parameter int LVL_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             en,
    input  fifo_req_t        req,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout,
    output logic [LVL_W-1:0] level,
    output fifo_flags_t      flags
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] DEPTH_C   = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;
    logic [CNT_W-1:0] count;
    logic [W-1:0]     last_q;
    logic             ovf_q;
    logic             udf_q;
    logic             full_w;
    logic             half_w;
    logic             empty_w;
    logic             do_push;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    fifo_level_enc #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W),
        .LVL_W (LVL_W)
    ) u_enc (
        .count (count),
        .en    (en),
        .level (level),
        .half  (half_w),
        .full  (full_w)
    );

    assign empty_w = (count == '0);
    assign do_push = req.push && !full_w && !req.flush;
    assign do_pop  = req.pop && !empty_w && !req.flush;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            last_q <= '0;
            ovf_q  <= 1'b0;
            udf_q  <= 1'b0;
        end else if (req.flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= step_ptr(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= step_ptr(rd_ptr);
                last_q <= mem[rd_ptr];
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (req.push && full_w) begin
                ovf_q <= 1'b1;
            end
            if (req.pop && empty_w) begin
                udf_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !clear && do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    assign dout = empty_w ? last_q : mem[rd_ptr];

    always_comb begin
        flags.half = half_w;
        flags.full = full_w;
        flags.ovf  = ovf_q;
        flags.udf  = udf_q;
    end

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= DEPTH_C);

    // R4
    wrap_full_chk: assert property (@(posedge clk) disable iff (rst)
        (count == DEPTH_C) |-> (level == '0 && flags.full));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (req.push && flags.full && !req.pop && !req.flush && !clear) |=> $stable(count));

    // R6
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (req.push && flags.full && !req.flush && !clear) |=> flags.ovf);

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flags.ovf && !clear) |=> flags.ovf);

    // R7
    udf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (req.pop && count == '0 && !req.flush && !clear) |=> flags.udf);

    // R7
    empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req.pop && count == '0 && !req.push && !req.flush && !clear) |=> $stable(dout));

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (req.flush && !clear) |=> (level == '0 && !flags.full && !flags.half));

endmodule

// File: rtl/soft_reset_guard.sv
module soft_reset_guard (
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic rx_busy,
    output logic clear,
    output logic busy_err
);

    logic busy_q;

    assign clear    = soft_rst && !rx_busy;
    assign busy_err = busy_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            busy_q <= 1'b0;
        end else if (soft_rst) begin
            busy_q <= 1'b1;
        end
    end

    // R11
    busy_set_chk: assert property (@(posedge clk) disable iff (rst)
        (soft_rst && rx_busy) |=> busy_err);

    // R10
    busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (soft_rst && !rx_busy) |=> !busy_err);

endmodule

// File: rtl/dual_frame_fifo.sv
module dual_frame_fifo
    import fifo_pair_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    parameter int LVL_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tx_en,
    input  logic               rx_en,
    input  logic               soft_rst,
    input  logic               tx_push,
    input  logic [DATA_W-1:0]  tx_byte,
    input  logic               tx_flush,
    input  logic               tx_pop,
    output logic [FRAME_W-1:0] tx_frame,
    output logic [LVL_W-1:0]   tx_level,
    output logic               tx_half,
    output logic               tx_full,
    output logic               tx_ovf,
    output logic               tx_udf,
    input  logic               rx_push,
    input  logic [FRAME_W-1:0] rx_frame,
    input  logic               rx_flush,
    input  logic               rx_pop,
    output logic [DATA_W-1:0]  rx_byte,
    output logic [LVL_W-1:0]   rx_level,
    output logic               rx_half,
    output logic               rx_full,
    output logic               rx_ovf,
    output logic               rx_udf,
    output logic               busy_err
);

    localparam int N_CH  = 2;
    localparam int CH_TX = 0;
    localparam int CH_RX = 1;

    logic        en_v   [N_CH];
    fifo_req_t   req_v  [N_CH];
    frame_t      din_v  [N_CH];
    frame_t      dout_v [N_CH];
    logic [LVL_W-1:0] lvl_v [N_CH];
    fifo_flags_t flg_v  [N_CH];
    logic        clear;
    logic        rx_busy;

    always_comb begin
        en_v[CH_TX]        = tx_en;
        req_v[CH_TX].push  = tx_push;
        req_v[CH_TX].pop   = tx_pop;
        req_v[CH_TX].flush = tx_flush;
        din_v[CH_TX]       = frame_from_byte(tx_byte);
        en_v[CH_RX]        = rx_en;
        req_v[CH_RX].push  = rx_push;
        req_v[CH_RX].pop   = rx_pop;
        req_v[CH_RX].flush = rx_flush;
        din_v[CH_RX]       = rx_frame;
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        frame_fifo #(
            .DEPTH (DEPTH),
            .W     (FRAME_W),
            .LVL_W (LVL_W)
        ) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .clear (clear),
            .en    (en_v[c]),
            .req   (req_v[c]),
            .din   (din_v[c]),
            .dout  (dout_v[c]),
            .level (lvl_v[c]),
            .flags (flg_v[c])
        );
    end

    assign rx_busy = (lvl_v[CH_RX] != '0) || flg_v[CH_RX].full;

    soft_reset_guard u_guard (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .rx_busy  (rx_busy),
        .clear    (clear),
        .busy_err (busy_err)
    );

    assign tx_frame = dout_v[CH_TX];
    assign tx_level = lvl_v[CH_TX];
    assign tx_half  = flg_v[CH_TX].half;
    assign tx_full  = flg_v[CH_TX].full;
    assign tx_ovf   = flg_v[CH_TX].ovf;
    assign tx_udf   = flg_v[CH_TX].udf;
    assign rx_byte  = byte_from_frame(dout_v[CH_RX]);
    assign rx_level = lvl_v[CH_RX];
    assign rx_half  = flg_v[CH_RX].half;
    assign rx_full  = flg_v[CH_RX].full;
    assign rx_ovf   = flg_v[CH_RX].ovf;
    assign rx_udf   = flg_v[CH_RX].udf;

endmodule

// File: tb/tb_dual_frame_fifo.sv
`timescale 1ns/1ps
module tb_dual_frame_fifo;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_en = 1'b1, rx_en = 1'b1, soft_rst = 1'b0;
    logic tx_push = 1'b0, tx_flush = 1'b0, tx_pop = 1'b0;
    logic [7:0] tx_byte = '0;
    logic rx_push = 1'b0, rx_flush = 1'b0, rx_pop = 1'b0;
    logic [8:0] rx_frame = '0;
    logic [8:0] tx_frame;
    logic [7:0] rx_byte;
    logic [2:0] tx_level, rx_level;
    logic tx_half, tx_full, tx_ovf, tx_udf;
    logic rx_half, rx_full, rx_ovf, rx_udf, busy_err;

    always #2.5 clk = ~clk;

    dual_frame_fifo dut (
        .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en), .soft_rst(soft_rst),
        .tx_push(tx_push), .tx_byte(tx_byte), .tx_flush(tx_flush), .tx_pop(tx_pop),
        .tx_frame(tx_frame), .tx_level(tx_level), .tx_half(tx_half), .tx_full(tx_full),
        .tx_ovf(tx_ovf), .tx_udf(tx_udf),
        .rx_push(rx_push), .rx_frame(rx_frame), .rx_flush(rx_flush), .rx_pop(rx_pop),
        .rx_byte(rx_byte), .rx_level(rx_level), .rx_half(rx_half), .rx_full(rx_full),
        .rx_ovf(rx_ovf), .rx_udf(rx_udf), .busy_err(busy_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model
    logic [8:0] txq[$];
    logic [8:0] rxq[$];
    logic [8:0] tx_last = '0, rx_last = '0;
    bit m_tx_ovf, m_tx_udf, m_rx_ovf, m_rx_udf, m_busy;

    function automatic int cap_of(input logic en);
        return en ? 8 : 1;
    endfunction

    task automatic check(input string tag, input string name,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, name, act, exp);
        end
    endtask

    task automatic model_clear();
        txq.delete(); rxq.delete();
        tx_last = '0; rx_last = '0;
        m_tx_ovf = 0; m_tx_udf = 0; m_rx_ovf = 0; m_rx_udf = 0; m_busy = 0;
    endtask

    task automatic model_step();
        bit dp, dq;
        if (soft_rst && rxq.size() == 0) begin
            model_clear();
            return;
        end
        if (soft_rst) m_busy = 1;
        if (!tx_flush) begin
            dp = tx_push && (txq.size() < cap_of(tx_en));
            dq = tx_pop && (txq.size() > 0);
            if (tx_push && !dp) m_tx_ovf = 1;
            if (tx_pop && !dq) m_tx_udf = 1;
            if (dq) tx_last = txq.pop_front();
            if (dp) txq.push_back({tx_byte, 1'b1});
        end else txq.delete();
        if (!rx_flush) begin
            dp = rx_push && (rxq.size() < cap_of(rx_en));
            dq = rx_pop && (rxq.size() > 0);
            if (rx_push && !dp) m_rx_ovf = 1;
            if (rx_pop && !dq) m_rx_udf = 1;
            if (dq) rx_last = rxq.pop_front();
            if (dp) rxq.push_back(rx_frame);
        end else rxq.delete();
    endtask

    task automatic check_all();
        logic [8:0] th, rh;
        th = (txq.size() > 0) ? txq[0] : tx_last;
        rh = (rxq.size() > 0) ? rxq[0] : rx_last;
        check("R2", "tx_frame", 32'(tx_frame), 32'(th));
        check("R4", "tx_level", 32'(tx_level), 32'(txq.size() % 8));
        check("R4", "tx_full", 32'(tx_full), 32'(txq.size() >= cap_of(tx_en)));
        check("R5", "tx_half", 32'(tx_half), 32'(txq.size() >= 4));
        check("R6", "tx_ovf", 32'(tx_ovf), 32'(m_tx_ovf));
        check("R7", "tx_udf", 32'(tx_udf), 32'(m_tx_udf));
        check("R3", "rx_byte", 32'(rx_byte), 32'(rh[8:1]));
        check("R4", "rx_level", 32'(rx_level), 32'(rxq.size() % 8));
        check("R4", "rx_full", 32'(rx_full), 32'(rxq.size() >= cap_of(rx_en)));
        check("R5", "rx_half", 32'(rx_half), 32'(rxq.size() >= 4));
        check("R6", "rx_ovf", 32'(rx_ovf), 32'(m_rx_ovf));
        check("R7", "rx_udf", 32'(rx_udf), 32'(m_rx_udf));
        check("R11", "busy_err", 32'(busy_err), 32'(m_busy));
    endtask

    task automatic idle();
        soft_rst = 0; tx_push = 0; tx_pop = 0; tx_flush = 0;
        rx_push = 0; rx_pop = 0; rx_flush = 0;
    endtask

    // inputs already set at a falling edge; result checked one edge later
    task automatic tick();
        model_step();
        @(negedge clk);
        check_all();
        idle();
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
        end
    end

    initial begin
        int r;
        model_clear();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1", "tx_level", 32'(tx_level), 0);
        check("R1", "rx_level", 32'(rx_level), 0);
        check("R1", "flags", 32'({tx_half, tx_full, tx_ovf, tx_udf, rx_half, rx_full,
                                  rx_ovf, rx_udf, busy_err}), 0);
        check("R1", "data", 32'({tx_frame, rx_byte}), 0);

        // fill transmit queue to 8
        for (int i = 0; i < 8; i++) begin
            tx_push = 1; tx_byte = 8'hA5 + 8'(i); tick();
        end
        check("R4", "tx wrap level", 32'(tx_level), 0);
        check("R4", "tx wrap full", 32'(tx_full), 1);
        check("R2", "tx head frame", 32'(tx_frame), 32'({8'hA5, 1'b1}));
        // ninth push dropped
        tx_push = 1; tx_byte = 8'h3C; tick();
        check("R6", "tx ovf", 32'(tx_ovf), 1);
        check("R6", "tx head kept", 32'(tx_frame), 32'({8'hA5, 1'b1}));
        // drain in order
        for (int i = 0; i < 8; i++) begin
            tx_pop = 1; tick();
        end
        // pop empty
        tx_pop = 1; tick();
        check("R7", "tx udf", 32'(tx_udf), 1);
        check("R7", "tx last held", 32'(tx_frame), 32'({8'hAC, 1'b1}));

        // fill receive queue to 8
        for (int i = 0; i < 8; i++) begin
            rx_push = 1; rx_frame = 9'(9'h101 + 9'(i * 37)); tick();
        end
        check("R4", "rx wrap level", 32'(rx_level), 0);
        check("R4", "rx ready", 32'(rx_full), 1);
        check("R5", "rx half", 32'(rx_half), 1);
        // refused soft reset
        soft_rst = 1; tick();
        check("R11", "busy_err set", 32'(busy_err), 1);
        check("R11", "rx kept", 32'(rx_full), 1);
        // flush receive only
        tx_push = 1; tx_byte = 8'h11; tick();
        rx_flush = 1; rx_push = 1; tick();
        check("R9", "rx flushed", 32'({rx_level, rx_full}), 0);
        check("R9", "tx untouched", 32'(tx_level), 1);
        check("R9", "rx sticky kept", 32'(busy_err), 1);
        // simultaneous push and pop
        tx_push = 1; tx_byte = 8'h22; tick();
        tx_push = 1; tx_pop = 1; tx_byte = 8'h33; tick();
        check("R12", "tx level same", 32'(tx_level), 2);
        check("R12", "tx order", 32'(tx_frame), 32'({8'h22, 1'b1}));
        // accepted soft reset
        soft_rst = 1; tx_push = 1; tick();
        check("R10", "busy cleared", 32'(busy_err), 0);
        check("R10", "all clear", 32'({tx_level, tx_ovf, tx_udf, rx_ovf, tx_frame}), 0);
        // bypass mode
        tx_en = 0; @(negedge clk); check_all();
        tx_push = 1; tx_byte = 8'h5A; tick();
        check("R8", "bypass full", 32'(tx_full), 1);
        tx_push = 1; tx_byte = 8'h6B; tick();
        check("R8", "bypass drop", 32'({tx_level, tx_ovf}), 32'({3'd1, 1'b1}));
        tx_pop = 1; tick();
        check("R8", "bypass data", 32'(tx_frame), 32'({8'h5A, 1'b1}));
        tx_en = 1; @(negedge clk); check_all();

        // seeded random run
        r = $urandom(32'h5EED_0042);
        for (int c = 0; c < 6000; c++) begin
            r = $urandom;
            tx_push  = (r[3:0] < 8);
            tx_pop   = (r[7:4] < 7);
            rx_push  = (r[11:8] < 8);
            rx_pop   = (r[15:12] < 7);
            tx_flush = (r[21:16] == 0);
            rx_flush = (r[21:16] == 1);
            soft_rst = (r[21:16] == 2) || (r[21:16] == 3);
            if (r[29:24] == 0) tx_en = ~tx_en;
            if (r[29:24] == 1) rx_en = ~rx_en;
            tx_byte  = 8'($urandom);
            rx_frame = 9'($urandom);
            tick();
        end

        done = 1'b1;
        report();
    end

endmodule